// File: doc/BRIEF.md
# Power Button Press Stretcher

This block sits between a debounced, active-low push-button level and the active-low power-button line of a host chipset. The chipset forces a hard reset when its line is held low for about 4 s. When the chipset is running, the block turns one long press into a short wake pulse, then a timed high gap, then a re-assertion that lasts until release. This moves the chipset's forced-reset point to about 8 s after the user first pressed.

The block also stretches presses made while the chipset is off, so the chipset has time to wake. It forces wake pulses on a lid-open edge and after a boot-time power-on request. It waits for a power-permitted flag before the boot pulse, and it swallows the release that follows a boot pulse held through by the user. While the chipset is off and power is not permitted, any low request on the line is overridden to high. All durations are whole milliseconds, counted by a clock prescaler.

Top module: `pwrbtn_stretch`

## Requirements
- R1: After a synchronous reset the line `pwrbtn_n` is high (1 = released), the block is idle and pulse mode is enabled.
- R2: A press (`btn_n` falling to 0) while `chip_off`=0 and pulse mode is enabled drives `pwrbtn_n` low in the next cycle for T0_MS ms. The line then goes high for T1_MS ms. If the button is still held after that, the line goes low again until release. One ms is CLK_PER_MS clocks.
- R3: With pulse mode disabled, a press while the chipset is on keeps the line high for T1_MS ms and then drives it low until release.
- R4: If `chip_off`=1 when the T1_MS gap ends, the line stays high for the rest of the press.
- R5: A press while `chip_off`=1 drives the line low for WAKE_MS ms. If the button is still held at the end, the line stays low until release. Otherwise it goes high.
- R6: A release during the short pulse, the gap or the re-assertion drives the line high in the next cycle, and the line stays high afterwards.
- R7: A rising edge of `lid_open` while `chip_off`=1, outside the boot power-on wait, forces a WAKE_MS ms low pulse. The same edge with the chipset on has no effect.
- R8: Button presses and releases are ignored during the off-press stretch, the lid pulse, the boot wait and the boot pulse.
- R9: After `init_req`, the block checks `pwr_ok` at once and then every POLL_MS ms, with the line kept high. Once `pwr_ok` is seen, the line is driven low for WAKE_MS ms. If `pwr_ok` has not been seen within INIT_TMO_MS ms, the block returns to idle at the next check.
- R10: If the button is held when the boot pulse ends, the line goes high. The next release then produces no edge, and the press after it is handled normally.
- R11: While `chip_off`=1 and `pwr_ok`=0, `pwrbtn_n` is high in the following cycle, whatever is requested.
- R12: `pulse_cfg_we` loads the pulse mode from `pulse_cfg_val`. `chip_evt` sets pulse mode to enabled and wins when both are asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n | input | 1 | Debounced button level, 0 = pressed |
| chip_off | input | 1 | 1 while the chipset is in any off state |
| lid_open | input | 1 | Lid level, rising edge = lid opened |
| pwr_ok | input | 1 | 1 when enough power is available to switch on |
| init_req | input | 1 | One-cycle request to start the boot power-on sequence |
| pulse_cfg_we | input | 1 | Write strobe for the pulse mode |
| pulse_cfg_val | input | 1 | Pulse mode value written by `pulse_cfg_we` |
| chip_evt | input | 1 | Chipset startup/shutdown/suspend/resume strobe; re-enables pulse mode |
| pwrbtn_n | output | 1 | Registered active-low power-button line to the chipset |

## Verification
The hardest state to reach from the ports is the swallowed release. To get there, the button has to be pressed during the boot wait, held through the whole boot pulse, and then released with the chipset already on. The stimulus raises `init_req` with `pwr_ok` set, pulls `btn_n` low in the same cycle, keeps it low past the pulse, and then checks that the release leaves the line quiet and that a fresh press still produces a short pulse. The boot-wait timeout needs a similar sequence: `pwr_ok` is kept low past INIT_TMO_MS, and a later press must then produce a short pulse, which proves the block left the wait. Press length is also swept cycle by cycle across every phase boundary, with the chipset both on and off.

// File: rtl/pb_pkg.sv
package pb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_T0,
    ST_T1,
    ST_HELD,
    ST_LID,
    ST_EAT,
    ST_INIT,
    ST_BOOT,
    ST_WASOFF
  } pb_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pb_edge_det.sv
// Registers the previous level of each input bit and flags a change.
module pb_edge_det #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= RST_VAL[i];
      else     prev_q[i] <= sig[i];
    end
    assign chg[i] = sig[i] ^ prev_q[i];
  end
endmodule

// File: rtl/pb_ms_timer.sv
// Millisecond down-counter. A load restarts the prescaler, so a load of N
// produces done exactly N*CLK_PER_MS cycles later.
module pb_ms_timer #(
  parameter int CLK_PER_MS = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          done
);
  localparam int PW = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_MS - 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      pre_q <= '0;
      cnt_q <= len;
    end else if (cnt_q != '0) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= cnt_q - CW'(1);
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end

  assign done = tick && (cnt_q == CW'(1));
endmodule

// File: rtl/pwrbtn_stretch.sv
module pwrbtn_stretch
  import pb_pkg::*;
#(
  parameter int CLK_PER_MS  = 50000,
  parameter int T0_MS       = 32,
  parameter int T1_MS       = 3968,
  parameter int WAKE_MS     = 200,
  parameter int POLL_MS     = 100,
  parameter int INIT_TMO_MS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n,
  input  logic chip_off,
  input  logic lid_open,
  input  logic pwr_ok,
  input  logic init_req,
  input  logic pulse_cfg_we,
  input  logic pulse_cfg_val,
  input  logic chip_evt,
  output logic pwrbtn_n
);
  localparam int TMR_MAX = max2(max2(T0_MS, T1_MS), max2(WAKE_MS, POLL_MS));
  localparam int TW = $clog2(TMR_MAX + 1);
  localparam int OW = $clog2(INIT_TMO_MS + 1);
  localparam logic [TW-1:0] LEN_T0   = TW'(T0_MS);
  localparam logic [TW-1:0] LEN_T1   = TW'(T1_MS);
  localparam logic [TW-1:0] LEN_WAKE = TW'(WAKE_MS);
  localparam logic [TW-1:0] LEN_POLL = TW'(POLL_MS);
  localparam logic [OW-1:0] LEN_TMO  = OW'(INIT_TMO_MS);

  pb_state_e     st_q, st_d;
  logic          want_lo_q, want_lo_d;
  logic          out_q;
  logic          chk_q, chk_d;
  logic          tmo_hit_q;
  logic          pulse_en_q;
  logic [1:0]    chg;
  logic          btn_press, btn_rel, lid_rise, held;
  logic          tmr_ld, tmr_done;
  logic [TW-1:0] tmr_len;
  logic          tmo_done;

  pb_edge_det #(.W(2), .RST_VAL(2'b01)) u_edge (
    .clk (clk),
    .rst (rst),
    .sig ({lid_open, btn_n}),
    .chg (chg)
  );

  assign held      = ~btn_n;
  assign btn_press = chg[0] & held;
  assign btn_rel   = chg[0] & btn_n;
  assign lid_rise  = chg[1] & lid_open;

  pb_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .CW(TW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_ld),
    .len  (tmr_len),
    .done (tmr_done)
  );

  pb_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .CW(OW)) u_tmo (
    .clk  (clk),
    .rst  (rst),
    .load (init_req),
    .len  (LEN_TMO),
    .done (tmo_done)
  );

  always_comb begin
    st_d      = st_q;
    want_lo_d = want_lo_q;
    tmr_ld    = 1'b0;
    tmr_len   = LEN_POLL;
    chk_d     = 1'b0;
    if (init_req) begin
      st_d      = ST_INIT;
      want_lo_d = 1'b0;
      tmr_ld    = 1'b1;
      tmr_len   = LEN_POLL;
      chk_d     = 1'b1;
    end else if (lid_rise && chip_off && st_q != ST_INIT) begin
      st_d      = ST_LID;
      want_lo_d = 1'b1;
      tmr_ld    = 1'b1;
      tmr_len   = LEN_WAKE;
    end else begin
      case (st_q)
        ST_IDLE, ST_T0, ST_T1, ST_HELD, ST_EAT: begin
          if (btn_press) begin
            tmr_ld = 1'b1;
            if (chip_off) begin
              st_d      = ST_WASOFF;
              want_lo_d = 1'b1;
              tmr_len   = LEN_WAKE;
            end else if (pulse_en_q) begin
              st_d      = ST_T0;
              want_lo_d = 1'b1;
              tmr_len   = LEN_T0;
            end else begin
              st_d    = ST_T1;
              tmr_len = LEN_T1;
            end
          end else if (btn_rel) begin
            st_d = ST_IDLE;
            if (st_q != ST_EAT) want_lo_d = 1'b0;
          end else if (tmr_done && st_q == ST_T0) begin
            st_d      = ST_T1;
            want_lo_d = 1'b0;
            tmr_ld    = 1'b1;
            tmr_len   = LEN_T1;
          end else if (tmr_done && st_q == ST_T1) begin
            st_d = ST_HELD;
            if (!chip_off) want_lo_d = 1'b1;
          end
        end
        ST_WASOFF: begin
          if (tmr_done) begin
            if (held) begin
              st_d = ST_HELD;
            end else begin
              st_d      = ST_IDLE;
              want_lo_d = 1'b0;
            end
          end
        end
        ST_LID: begin
          if (tmr_done) begin
            st_d      = ST_IDLE;
            want_lo_d = 1'b0;
          end
        end
        ST_BOOT: begin
          if (tmr_done) begin
            st_d      = held ? ST_EAT : ST_IDLE;
            want_lo_d = 1'b0;
          end
        end
        ST_INIT: begin
          if (chk_q || tmr_done) begin
            if (pwr_ok) begin
              st_d      = ST_BOOT;
              want_lo_d = 1'b1;
              tmr_ld    = 1'b1;
              tmr_len   = LEN_WAKE;
            end else if (tmo_hit_q) begin
              st_d = ST_IDLE;
            end else begin
              tmr_ld  = 1'b1;
              tmr_len = LEN_POLL;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      want_lo_q  <= 1'b0;
      out_q      <= 1'b1;
      chk_q      <= 1'b0;
      tmo_hit_q  <= 1'b0;
      pulse_en_q <= 1'b1;
    end else begin
      st_q      <= st_d;
      want_lo_q <= want_lo_d;
      out_q     <= ~(want_lo_d & ~(chip_off & ~pwr_ok));
      chk_q     <= chk_d;
      if (init_req)      tmo_hit_q <= 1'b0;
      else if (tmo_done) tmo_hit_q <= 1'b1;
      if (chip_evt)          pulse_en_q <= 1'b1;
      else if (pulse_cfg_we) pulse_en_q <= pulse_cfg_val;
    end
  end

  assign pwrbtn_n = out_q;
endmodule

// File: rtl/pwrbtn_stretch_chk.sv
module pwrbtn_stretch_chk
  import pb_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      chip_off,
  input logic      pwr_ok,
  input logic      chip_evt,
  input logic      pwrbtn_n,
  input logic      pulse_en_q,
  input pb_state_e st_q
);
  // R1: reset leaves the line released
  p_rst_high_r1: assert property (@(posedge clk) rst |=> pwrbtn_n);

  // R11: no low drive while off without power permission
  p_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (chip_off && !pwr_ok) |=> pwrbtn_n);

  // R12: chipset event re-enables pulse mode
  p_restore_r12: assert property (@(posedge clk) disable iff (rst)
    chip_evt |=> pulse_en_q);

  // R10: line stays released while a release is being swallowed
  p_eat_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_EAT) |-> pwrbtn_n);

  // R9: line stays released during the boot power-on wait
  p_init_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_INIT) |-> pwrbtn_n);
endmodule

bind pwrbtn_stretch pwrbtn_stretch_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .chip_off   (chip_off),
  .pwr_ok     (pwr_ok),
  .chip_evt   (chip_evt),
  .pwrbtn_n   (pwrbtn_n),
  .pulse_en_q (pulse_en_q),
  .st_q       (st_q)
);

// File: tb/pwrbtn_stretch_tb_top.sv
module pwrbtn_stretch_tb_top;
  localparam int DIV = 4, T0 = 3, T1 = 5, WAKE = 4, POLL = 2, TMO = 5;
  localparam int T0C = T0 * DIV, T1C = T1 * DIV, WAKEC = WAKE * DIV;

  logic clk = 1'b0, rst = 1'b1;
  logic btn_n = 1'b1, chip_off = 1'b0, lid_open = 1'b0, pwr_ok = 1'b1;
  logic init_req = 1'b0, pulse_cfg_we = 1'b0, pulse_cfg_val = 1'b0, chip_evt = 1'b0;
  logic pwrbtn_n;
  int   n_chk = 0, n_bad = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  pwrbtn_stretch #(
    .CLK_PER_MS(DIV), .T0_MS(T0), .T1_MS(T1), .WAKE_MS(WAKE),
    .POLL_MS(POLL), .INIT_TMO_MS(TMO)
  ) dut_i (
    .clk(clk), .rst(rst), .btn_n(btn_n), .chip_off(chip_off),
    .lid_open(lid_open), .pwr_ok(pwr_ok), .init_req(init_req),
    .pulse_cfg_we(pulse_cfg_we), .pulse_cfg_val(pulse_cfg_val),
    .chip_evt(chip_evt), .pwrbtn_n(pwrbtn_n)
  );

  task automatic chk_now(input logic lvl, input string req);
    n_chk++;
    if (pwrbtn_n !== lvl) begin
      n_bad++;
      $display("FAIL %s at %0t: pwrbtn_n=%b expected %b", req, $time, pwrbtn_n, lvl);
    end
  endtask

  task automatic expect_for(input logic lvl, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_now(lvl, req);
    end
  endtask

  function automatic logic exp_on(input int k, input int h);
    if (k >= h) return 1'b1;
    return !(k < T0C || k >= T0C + T1C);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_for(1'b1, 4, "R1");

    // R2/R6: sweep press length with chipset on, pulse mode enabled
    for (int h = 1; h <= T0C + T1C + 8; h++) begin
      btn_n = 1'b0;
      for (int k = 0; k < T0C + T1C + 12; k++) begin
        @(negedge clk);
        chk_now(exp_on(k, h), (h < T0C + T1C) ? "R6" : "R2");
        if (k == h - 1) btn_n = 1'b1;
      end
    end

    // R5/R8: sweep press length with chipset off
    chip_off = 1'b1;
    for (int h = 1; h <= WAKEC + 6; h++) begin
      btn_n = 1'b0;
      for (int k = 0; k < WAKEC + 10; k++) begin
        @(negedge clk);
        chk_now((k < ((h > WAKEC) ? h : WAKEC)) ? 1'b0 : 1'b1, (h < WAKEC) ? "R8" : "R5");
        if (k == h - 1) btn_n = 1'b1;
      end
    end
    chip_off = 1'b0;

    // R3: pulse mode disabled
    pulse_cfg_we = 1'b1; pulse_cfg_val = 1'b0;
    @(negedge clk); pulse_cfg_we = 1'b0;
    btn_n = 1'b0;
    expect_for(1'b1, T1C, "R3");
    expect_for(1'b0, 5, "R3");
    btn_n = 1'b1;
    expect_for(1'b1, 3, "R3");

    // R12: chipset event beats a simultaneous disable write
    pulse_cfg_we = 1'b1; pulse_cfg_val = 1'b0; chip_evt = 1'b1;
    @(negedge clk); pulse_cfg_we = 1'b0; chip_evt = 1'b0;
    btn_n = 1'b0;
    expect_for(1'b0, T0C, "R12");
    btn_n = 1'b1;
    expect_for(1'b1, 3, "R12");

    // R4: chipset turns off during the gap
    btn_n = 1'b0;
    expect_for(1'b0, T0C, "R4");
    expect_for(1'b1, T1C - 2, "R4");
    chip_off = 1'b1;
    expect_for(1'b1, 12, "R4");
    btn_n = 1'b1;
    expect_for(1'b1, 4, "R4");

    // R11: off and no power permission
    pwr_ok = 1'b0;
    btn_n = 1'b0;
    expect_for(1'b1, WAKEC + 4, "R11");
    btn_n = 1'b1;
    expect_for(1'b1, 4, "R11");
    pwr_ok = 1'b1;

    // R7: lid pulse while off, then press during it is ignored (R8)
    lid_open = 1'b1;
    expect_for(1'b0, 3, "R7");
    btn_n = 1'b0;
    expect_for(1'b0, WAKEC - 3, "R8");
    expect_for(1'b1, 4, "R8");
    btn_n = 1'b1;
    expect_for(1'b1, 2, "R8");
    lid_open = 1'b0;
    chip_off = 1'b0;
    expect_for(1'b1, 2, "R7");
    lid_open = 1'b1;
    expect_for(1'b1, 10, "R7");
    lid_open = 1'b0;
    expect_for(1'b1, 2, "R7");

    // R9: boot wait gives up, then a press works normally
    pwr_ok = 1'b0;
    init_req = 1'b1;
    @(negedge clk); init_req = 1'b0; chk_now(1'b1, "R9");
    expect_for(1'b1, 40, "R9");
    pwr_ok = 1'b1;
    btn_n = 1'b0;
    expect_for(1'b0, T0C, "R9");
    btn_n = 1'b1;
    expect_for(1'b1, 3, "R9");

    // R9: permission arrives between polls
    pwr_ok = 1'b0; chip_off = 1'b1;
    init_req = 1'b1;
    @(negedge clk); init_req = 1'b0; chk_now(1'b1, "R9");
    expect_for(1'b1, 3, "R9");
    pwr_ok = 1'b1;
    expect_for(1'b1, 5, "R9");
    expect_for(1'b0, WAKEC, "R9");
    expect_for(1'b1, 4, "R9");

    // R10: button held across boot pulse; release swallowed
    init_req = 1'b1; btn_n = 1'b0;
    @(negedge clk); init_req = 1'b0; chk_now(1'b1, "R10");
    expect_for(1'b0, WAKEC, "R10");
    expect_for(1'b1, 4, "R10");
    chip_off = 1'b0;
    expect_for(1'b1, 2, "R10");
    btn_n = 1'b1;
    expect_for(1'b1, 8, "R10");
    btn_n = 1'b0;
    expect_for(1'b0, T0C, "R10");
    btn_n = 1'b1;
    expect_for(1'b1, 3, "R10");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule